// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides whether a 32-bit logical address lies inside one of two transparent translation windows. An address inside a window skips the page-table walk and is used as the physical address unchanged. Each window is programmed through a 32-bit configuration word. Only three of its fields take part in the decision: an enable bit, an 8-bit base value and an 8-bit don't-care mask. The comparison covers the top byte of the address and nothing else.

The block takes the address and the configuration words of all windows. It returns a hit flag, the index of the winning window and the pass-through address. The lowest-numbered matching window wins. A parameter selects whether the outputs are registered (the default) or purely combinational. All field positions and widths are parameters, and elaboration-time checks guard them.

Top module: `ttw_matcher`

## Requirements
- R1: A window whose enable bit (configuration bit 15) is 0 never matches, whatever its base and mask hold.
- R2: The window base sits in configuration bits 31:24 and is compared bit by bit with logical address bits 31:24.
- R3: The window mask sits in configuration bits 23:16. A 1 in mask bit k+16 makes address bit k+24 a don't-care. A 0 requires that address bit to equal base bit k+24.
- R4: `tt_hit` is 1 exactly when at least one enabled window matches. It is 0 when every window is disabled or none matches.
- R5: When window 0 matches, `tt_win` is 0 whether or not window 1 also matches. When only window 1 matches, `tt_win` is 1.
- R6: On a hit, `pass_addr` equals the logical address unchanged.
- R7: On a miss, `pass_addr` is all zeros and `tt_win` is 0. No translated or descriptor address is reported.
- R8: Configuration bits 14:0 (function-code, read/write and cache attribute fields) have no effect on any output.
- R9: With the default registered output, every output reflects the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| lg_addr | input | 32 | Logical address to test |
| win_cfg | input | 64 | Window configuration words; window 0 in bits 31:0, window 1 in bits 63:32 |
| tt_hit | output | 1 | An enabled window contains the address |
| tt_win | output | 1 | Index of the matching window (lowest wins) |
| pass_addr | output | 32 | Logical address on a hit, zero on a miss |

## Verification
The bench sweeps all 256 mask values over the top byte. For each one it builds an address that differs from the base only in masked bits, which must hit. It also builds one that differs in a single unmasked bit, which must miss. An inverted mask sense or an off-by-one field slice fails almost at once. Further cases enable both windows so that both match, to catch a priority that favours window 1. Other cases leave the base matching while the enable is clear, to catch an enable taken from the wrong bit. Another case fills configuration bits 14:0 with noise, which exposes any decode that reads those bits. The reset check and the one-cycle output latency catch a missing or doubled output register.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
   localparam int unsigned TTW_ADDR_W   = 32;
   localparam int unsigned TTW_CFG_W    = 32;
   localparam int unsigned TTW_CMP_W    = 8;
   localparam int unsigned TTW_EN_BIT   = 15;
   localparam int unsigned TTW_BASE_LSB = 24;
   localparam int unsigned TTW_MASK_LSB = 16;
   localparam int unsigned TTW_NUM_WIN  = 2;

   function automatic int unsigned ttw_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ttw_cfg_unpack.sv
module ttw_cfg_unpack #(
   parameter int unsigned NUM_WIN  = ttw_pkg::TTW_NUM_WIN,
   parameter int unsigned CFG_W    = ttw_pkg::TTW_CFG_W,
   parameter int unsigned CMP_W    = ttw_pkg::TTW_CMP_W,
   parameter int unsigned EN_BIT   = ttw_pkg::TTW_EN_BIT,
   parameter int unsigned BASE_LSB = ttw_pkg::TTW_BASE_LSB,
   parameter int unsigned MASK_LSB = ttw_pkg::TTW_MASK_LSB
) (
   input  logic [NUM_WIN*CFG_W-1:0] cfg_flat,
   output logic [NUM_WIN-1:0]       en_vec,
   output logic [NUM_WIN*CMP_W-1:0] base_flat,
   output logic [NUM_WIN*CMP_W-1:0] mask_flat
);
   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int unsigned OFS = w * CFG_W;
      assign en_vec[w]                    = cfg_flat[OFS + EN_BIT];
      assign base_flat[w*CMP_W +: CMP_W]  = cfg_flat[OFS + BASE_LSB +: CMP_W];
      assign mask_flat[w*CMP_W +: CMP_W]  = cfg_flat[OFS + MASK_LSB +: CMP_W];
   end
endmodule

// File: rtl/ttw_window_cmp.sv
module ttw_window_cmp #(
   parameter int unsigned ADDR_W = ttw_pkg::TTW_ADDR_W,
   parameter int unsigned CMP_W  = ttw_pkg::TTW_CMP_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en,
   input  logic [CMP_W-1:0]  base,
   input  logic [CMP_W-1:0]  dc_mask,
   output logic              hit
);
   localparam int unsigned TOP_LSB = ADDR_W - CMP_W;

   logic [CMP_W-1:0] bit_ok;

   // each compared bit is satisfied by equality or by its don't-care flag
   for (genvar b = 0; b < CMP_W; b++) begin : g_bit
      assign bit_ok[b] = dc_mask[b] | ~(addr[TOP_LSB + b] ^ base[b]);
   end

   assign hit = en & (&bit_ok);
endmodule

// File: rtl/ttw_prio_sel.sv
module ttw_prio_sel #(
   parameter int unsigned NUM_WIN = ttw_pkg::TTW_NUM_WIN,
   localparam int unsigned IDX_W  = ttw_pkg::ttw_idx_w(NUM_WIN)
) (
   input  logic [NUM_WIN-1:0] hit_vec,
   output logic               any_hit,
   output logic [IDX_W-1:0]   win_idx
);
   // scan from the top so that the lowest index is written last and wins
   always_comb begin
      any_hit = 1'b0;
      win_idx = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            any_hit = 1'b1;
            win_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher #(
   parameter int unsigned ADDR_W   = ttw_pkg::TTW_ADDR_W,
   parameter int unsigned CFG_W    = ttw_pkg::TTW_CFG_W,
   parameter int unsigned CMP_W    = ttw_pkg::TTW_CMP_W,
   parameter int unsigned EN_BIT   = ttw_pkg::TTW_EN_BIT,
   parameter int unsigned BASE_LSB = ttw_pkg::TTW_BASE_LSB,
   parameter int unsigned MASK_LSB = ttw_pkg::TTW_MASK_LSB,
   parameter int unsigned NUM_WIN  = ttw_pkg::TTW_NUM_WIN,
   parameter bit          REG_OUT  = 1'b1,
   localparam int unsigned IDX_W   = ttw_pkg::ttw_idx_w(NUM_WIN)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        lg_addr,
   input  logic [NUM_WIN*CFG_W-1:0] win_cfg,
   output logic                     tt_hit,
   output logic [IDX_W-1:0]         tt_win,
   output logic [ADDR_W-1:0]        pass_addr
);
   // elaboration-time parameter checks
   if (NUM_WIN < 1) begin : g_chk_num
      $error("ttw_matcher: NUM_WIN must be at least 1");
   end
   if (CMP_W > ADDR_W) begin : g_chk_cmp
      $error("ttw_matcher: CMP_W exceeds ADDR_W");
   end
   if (BASE_LSB + CMP_W > CFG_W || MASK_LSB + CMP_W > CFG_W || EN_BIT >= CFG_W) begin : g_chk_fld
      $error("ttw_matcher: a window field lies outside the configuration word");
   end

   logic [NUM_WIN-1:0]       en_vec;
   logic [NUM_WIN*CMP_W-1:0] base_flat;
   logic [NUM_WIN*CMP_W-1:0] mask_flat;
   logic [NUM_WIN-1:0]       hit_vec;
   logic                     any_hit;
   logic [IDX_W-1:0]         win_idx;

   ttw_cfg_unpack #(
      .NUM_WIN (NUM_WIN),
      .CFG_W   (CFG_W),
      .CMP_W   (CMP_W),
      .EN_BIT  (EN_BIT),
      .BASE_LSB(BASE_LSB),
      .MASK_LSB(MASK_LSB)
   ) u_unpack (
      .cfg_flat (win_cfg),
      .en_vec   (en_vec),
      .base_flat(base_flat),
      .mask_flat(mask_flat)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
      ttw_window_cmp #(
         .ADDR_W(ADDR_W),
         .CMP_W (CMP_W)
      ) u_cmp (
         .addr   (lg_addr),
         .en     (en_vec[w]),
         .base   (base_flat[w*CMP_W +: CMP_W]),
         .dc_mask(mask_flat[w*CMP_W +: CMP_W]),
         .hit    (hit_vec[w])
      );
   end

   ttw_prio_sel #(
      .NUM_WIN(NUM_WIN)
   ) u_prio (
      .hit_vec(hit_vec),
      .any_hit(any_hit),
      .win_idx(win_idx)
   );

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tt_hit    <= 1'b0;
            tt_win    <= '0;
            pass_addr <= '0;
         end else begin
            tt_hit    <= any_hit;
            tt_win    <= win_idx;
            pass_addr <= any_hit ? lg_addr : '0;
         end
      end

      assert_off_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(~|en_vec)) |-> !tt_hit);
      assert_any_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(|hit_vec)) |-> tt_hit);
      assert_low_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && $past(hit_vec[0])) |-> (tt_hit && tt_win == '0));
      assert_pass_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (past_ok && tt_hit) |-> pass_addr == $past(lg_addr));
      assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !tt_hit |-> (pass_addr == '0 && tt_win == '0));
   end else begin : g_comb_out
      assign tt_hit    = any_hit;
      assign tt_win    = win_idx;
      assign pass_addr = any_hit ? lg_addr : '0;

      assert_off_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (~|en_vec) |-> !tt_hit);
      assert_low_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
         hit_vec[0] |-> (tt_win == '0));
      assert_pass_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
         tt_hit |-> pass_addr == lg_addr);
      assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !tt_hit |-> (pass_addr == '0 && tt_win == '0));
   end
endmodule

// File: tb/ttw_matcher_tb.sv
module ttw_matcher_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lg_addr = '0;
   logic [63:0] win_cfg = '0;
   logic        tt_hit;
   logic [0:0]  tt_win;
   logic [31:0] pass_addr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // expected results queued at drive time, popped one clock later
   bit    q_hit[$];
   int    q_win[$];
   int    q_addr[$];
   string q_tag[$];

   always #5 clk = ~clk;

   ttw_matcher u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .lg_addr  (lg_addr),
      .win_cfg  (win_cfg),
      .tt_hit   (tt_hit),
      .tt_win   (tt_win),
      .pass_addr(pass_addr)
   );

   function automatic logic [31:0] mk_cfg(input bit en, input logic [7:0] base,
                                          input logic [7:0] msk, input logic [14:0] junk);
      return {base, msk, en, junk};
   endfunction

   // behavioural window test written from R1..R3
   function automatic bit win_match(input logic [31:0] a, input logic [31:0] c);
      if (c[15] == 1'b0) return 0;
      for (int k = 0; k < 8; k++) begin
         if (c[16 + k] == 1'b0 && a[24 + k] != c[24 + k]) return 0;
      end
      return 1;
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // drive at a falling edge, check the previous drive's result at the next falling edge
   task automatic step(input string tag, input logic [31:0] a, input logic [31:0] c0,
                       input logic [31:0] c1);
      bit h0, h1, h;
      h0 = win_match(a, c0);
      h1 = win_match(a, c1);
      h  = h0 | h1;
      lg_addr = a;
      win_cfg = {c1, c0};
      q_hit.push_back(h);
      q_win.push_back(h0 ? 0 : (h1 ? 1 : 0));
      q_addr.push_back(h ? int'(a) : 0);
      q_tag.push_back(tag);
      @(negedge clk);
      begin
         bit    eh;
         int    ew, ea;
         string t;
         eh = q_hit.pop_front();
         ew = q_win.pop_front();
         ea = q_addr.pop_front();
         t  = q_tag.pop_front();
         chk({t, "/R4"}, "tt_hit", tt_hit, eh);
         chk({t, "/R5"}, "tt_win", tt_win, ew);
         chk({t, eh ? "/R6" : "/R7"}, "pass_addr", pass_addr, longint'(unsigned'(ea)));
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] lfsr;
      lfsr = 32'hACE1_1234;
      // R9: outputs held at zero during reset, even with a matching window applied
      lg_addr = 32'h4000_0010;
      win_cfg = {32'h0, mk_cfg(1, 8'h40, 8'h00, 15'h0)};
      repeat (3) @(negedge clk);
      chk("R9", "tt_hit in reset", tt_hit, 0);
      chk("R9", "pass_addr in reset", pass_addr, 0);
      chk("R9", "tt_win in reset", tt_win, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: one-cycle latency, the hit shows up after the edge that captured it
      lg_addr = 32'h1200_0000;
      win_cfg = {32'h0, mk_cfg(1, 8'h12, 8'h00, 15'h0)};
      @(posedge clk);
      #1;
      lg_addr = 32'h9900_0000;
      chk("R9", "latency tt_hit", tt_hit, 1);
      chk("R9", "latency pass_addr", pass_addr, 32'h1200_0000);
      @(negedge clk);
      chk("R9", "latency hold pass_addr", pass_addr, 32'h1200_0000);

      // R1: base matches but enable clear, both windows
      step("R1", 32'h3300_1000, mk_cfg(0, 8'h33, 8'h00, 15'h0), mk_cfg(0, 8'h33, 8'hFF, 15'h0));
      step("R1", 32'h3300_1000, mk_cfg(0, 8'h33, 8'hFF, 15'h0), mk_cfg(1, 8'h00, 8'h00, 15'h0));

      // R2: exact compare, all 256 top-byte values against base 5A
      for (int v = 0; v < 256; v++) begin
         step("R2", {v[7:0], 24'h00_ABCD}, mk_cfg(1, 8'h5A, 8'h00, 15'h0), 32'h0);
      end

      // R3: exhaustive mask sweep, one hitting and one missing address per mask
      for (int m = 0; m < 256; m++) begin
         logic [7:0] mk, flip;
         mk = m[7:0];
         flip = mk & 8'hA5;
         step("R3", {8'hC3 ^ flip, 24'h12_3456}, mk_cfg(1, 8'hC3, mk, 15'h0), 32'h0);
         if (mk != 8'hFF) begin
            logic [7:0] one;
            one = 8'h01;
            for (int k = 0; k < 8; k++) begin
               if (mk[k] == 1'b0) begin
                  one = 8'h01 << k;
                  break;
               end
            end
            step("R3", {8'hC3 ^ one, 24'h00_0001}, mk_cfg(1, 8'hC3, mk, 15'h0), 32'h0);
         end
      end

      // R5: both windows match -> window 0; only window 1 -> window 1
      step("R5", 32'h8000_0004, mk_cfg(1, 8'h80, 8'h0F, 15'h0), mk_cfg(1, 8'h80, 8'h00, 15'h0));
      step("R5", 32'h8100_0004, mk_cfg(1, 8'h70, 8'h00, 15'h0), mk_cfg(1, 8'h81, 8'h00, 15'h0));
      step("R5", 32'h8100_0004, mk_cfg(0, 8'h81, 8'h00, 15'h0), mk_cfg(1, 8'h80, 8'h01, 15'h0));
      step("R7", 32'h8100_0004, mk_cfg(1, 8'h70, 8'h00, 15'h0), mk_cfg(1, 8'h71, 8'h00, 15'h0));

      // R8: noise in bits 14:0 of both words, with LFSR addresses and windows
      for (int n = 0; n < 300; n++) begin
         logic [31:0] c0, c1, a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         c0 = mk_cfg(lfsr[3], a[31:24] ^ (lfsr[15:8] & lfsr[23:16]), lfsr[23:16], lfsr[14:0]);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         c1 = mk_cfg(lfsr[5], a[31:24] ^ (lfsr[15:8] & lfsr[23:16]), lfsr[23:16], lfsr[14:0]);
         step("R8", a, c0, c1);
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule